// File: doc/BRIEF.md
# Flash Erase-Block Lock State Manager

This block keeps a protection state for every erase block of a flash array and answers two questions about it: may a program or erase proceed at a given address, and what is the lock status of a given block for a configuration read. Each block is in one of three states: open (writable), shut (write-protected but releasable) or frozen (write-protected and immune to release until the next reset). Reset places every block in the shut state.

State changes arrive as single-cycle command strobes carrying an 8-bit opcode and an address. A change is accepted only when the command immediately before it, counting strobes and not idle cycles, was the configuration set-up opcode 0x60. A small sequencer with two states handles this. SEQ_IDLE moves to SEQ_ARMED on a set-up strobe. SEQ_ARMED returns to SEQ_IDLE on any other strobe, applying the lock (0x01), freeze (0x2F) or release (0xD0) action when the opcode is one of those, and stays in SEQ_ARMED on a further set-up strobe. Idle cycles leave it where it is. Each block cell is a three-state machine. LK_OPEN moves to LK_SHUT on lock and to LK_FROZEN on freeze. LK_SHUT moves to LK_OPEN on release and to LK_FROZEN on freeze. LK_FROZEN holds until reset.

The block index is the top log2(block count) bits of an address; the lower bits are ignored. A program or erase request aimed at a block that is not open raises a one-cycle fault pulse. The status register elsewhere in the chip turns this pulse into its block-lock error bit.

Top module: `blk_lock_mgr`

## Requirements
- R1: After reset every block reads status 0x01 and gives `op_permit` = 0.
- R2: Opcode 0x01 directly after 0x60 puts an open block into the shut state (status 0x01) at the next clock edge.
- R3: Opcode 0xD0 directly after 0x60 puts a shut block into the open state (status 0x00).
- R4: Opcode 0x2F directly after 0x60 puts a block in any state into the frozen state (status 0x03).
- R5: A frozen block stays frozen under 0x01 and 0xD0 until reset.
- R6: Opcodes 0x01, 0x2F and 0xD0 have no effect unless the previous command strobe was 0x60; any strobe other than 0x60 cancels a pending set-up.
- R7: A second 0x60 strobe keeps the set-up pending, and idle cycles between strobes do not cancel it.
- R8: `qry_status` is combinational: bit 0 is set when the block at `qry_addr` is shut or frozen, bit 1 when it is frozen, and bits 7:2 are zero. Only the top address bits select the block.
- R9: `op_permit` is 1 exactly when the block at `op_addr` is open.
- R10: `lock_fault` is high in the cycle after an `op_req` to a block that is not open, and low after every other cycle.
- R11: An action changes only the block selected by `cmd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_code | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Address whose top bits select the block |
| qry_addr | input | ADDR_W | Address for the status read |
| qry_status | output | 8 | Lock status of the block at `qry_addr` |
| op_req | input | 1 | Program or erase request strobe |
| op_addr | input | ADDR_W | Target address of the request |
| op_permit | output | 1 | Block at `op_addr` is open |
| lock_fault | output | 1 | Pulse: last request hit a protected block |

## Verification
The assertions assume that a command is sampled once per strobe and that the address top bits always name an existing block, which holds for the default power-of-two block count. The bench drives every input at the falling edge, so each strobe is seen at exactly one rising edge. It draws block indices only from the valid range and mixes random low address bits into every address. It also inserts idle gaps between set-up and action strobes, so that rule R7 is exercised without breaking the assumption that only strobes advance the sequencer.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_SHUT   = 2'd1,
        LK_FROZEN = 2'd2
    } lk_state_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic lock;
        logic unlock;
        logic freeze;
    } lk_act_t;

    localparam logic [7:0] OPC_SETUP  = 8'h60;
    localparam logic [7:0] OPC_LOCK   = 8'h01;
    localparam logic [7:0] OPC_FREEZE = 8'h2F;
    localparam logic [7:0] OPC_UNLOCK = 8'hD0;

endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    output lk_act_t           act,
    output logic [IDX_W-1:0]  act_idx
);

    seq_state_e cur_q;
    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SEQ_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt     = cur_q;
        act     = '0;
        act_idx = cmd_addr[ADDR_W-1 -: IDX_W];
        unique case (cur_q)
            SEQ_IDLE: begin
                if (cmd_valid && cmd_code == OPC_SETUP) nxt = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (cmd_valid) begin
                    act.lock   = (cmd_code == OPC_LOCK);
                    act.unlock = (cmd_code == OPC_UNLOCK);
                    act.freeze = (cmd_code == OPC_FREEZE);
                    nxt = (cmd_code == OPC_SETUP) ? SEQ_ARMED : SEQ_IDLE;
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
    end

    // R7
    setup_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OPC_SETUP) |=> (cur_q == SEQ_ARMED));

    // R6
    other_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code != OPC_SETUP) |=> (cur_q == SEQ_IDLE));

    // R6
    act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));

endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
    import blk_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel,
    input  lk_act_t   act,
    output lk_state_e st
);

    lk_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LK_SHUT;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (sel) begin
            unique case (st)
                LK_OPEN: begin
                    if (act.freeze)    nxt = LK_FROZEN;
                    else if (act.lock) nxt = LK_SHUT;
                end
                LK_SHUT: begin
                    if (act.freeze)      nxt = LK_FROZEN;
                    else if (act.unlock) nxt = LK_OPEN;
                end
                LK_FROZEN: nxt = LK_FROZEN;
                default:   nxt = LK_SHUT;
            endcase
        end
    end

    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_FROZEN) |=> (st == LK_FROZEN));

    // R11
    unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(st));

    // R4
    freeze_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && act.freeze) |=> (st == LK_FROZEN));

    // R2
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && act.lock) |=> (st != LK_OPEN));

    // R3
    unlock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && act.unlock && st == LK_SHUT) |=> (st == LK_OPEN));

endmodule

// File: rtl/blk_lock_view.sv
module blk_lock_view
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 20,
    parameter int IDX_W      = 4
) (
    input  logic [2*NUM_BLOCKS-1:0] st_flat,
    input  logic [ADDR_W-1:0]       qry_addr,
    input  logic [ADDR_W-1:0]       op_addr,
    output logic [7:0]              qry_status,
    output logic                    op_permit
);

    function automatic lk_state_e pick(input logic [2*NUM_BLOCKS-1:0] flat,
                                       input logic [ADDR_W-1:0] addr);
        lk_state_e r;
        logic [IDX_W-1:0] idx;
        idx = addr[ADDR_W-1 -: IDX_W];
        r   = LK_SHUT;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (int'(idx) == i) r = lk_state_e'(flat[2*i +: 2]);
        end
        return r;
    endfunction

    lk_state_e q_st;
    lk_state_e o_st;

    always_comb begin
        q_st       = pick(st_flat, qry_addr);
        o_st       = pick(st_flat, op_addr);
        qry_status = {6'b0, q_st == LK_FROZEN, q_st != LK_OPEN};
        op_permit  = (o_st == LK_OPEN);
    end

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int ADDR_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic [7:0]        qry_status,
    input  logic              op_req,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              op_permit,
    output logic              lock_fault
);

    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    lk_act_t                 act;
    logic [IDX_W-1:0]        act_idx;
    logic [2*NUM_BLOCKS-1:0] st_flat;

    blk_lock_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .act       (act),
        .act_idx   (act_idx)
    );

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cell
        logic      sel;
        lk_state_e st;
        assign sel = (act != '0) && (int'(act_idx) == g);
        blk_lock_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .act   (act),
            .st    (st)
        );
        assign st_flat[2*g +: 2] = st;
    end

    blk_lock_view #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_view (
        .st_flat    (st_flat),
        .qry_addr   (qry_addr),
        .op_addr    (op_addr),
        .qry_status (qry_status),
        .op_permit  (op_permit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_fault <= 1'b0;
        else        lock_fault <= op_req && !op_permit;
    end

    // R10
    fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_permit) |=> lock_fault);

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_req |=> !lock_fault);

    // R9
    permit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_addr[ADDR_W-1 -: IDX_W] == qry_addr[ADDR_W-1 -: IDX_W])
            |-> (op_permit == (qry_status[0] == 1'b0)));

    // R8
    status_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_status[7:2] == 6'b0) && (!qry_status[1] || qry_status[0]));

endmodule

// File: tb/blk_lock_mgr_test.sv
module blk_lock_mgr_test;

    localparam int NB = 16;
    localparam int AW = 20;
    localparam int IW = 4;
    localparam int SH = AW - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic [AW-1:0] qry_addr = '0;
    logic [7:0]    qry_status;
    logic          op_req = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          op_permit;
    logic          lock_fault;

    always #4 clk = ~clk;

    blk_lock_mgr #(.NUM_BLOCKS(NB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .qry_addr(qry_addr), .qry_status(qry_status),
        .op_req(op_req), .op_addr(op_addr), .op_permit(op_permit),
        .lock_fault(lock_fault)
    );

    int n_chk = 0;
    int n_bad = 0;
    int mdl[NB];     // 0 open, 1 shut, 2 frozen
    bit armed;
    bit exp_fault;
    int mb;

    function automatic int blk_of(logic [AW-1:0] a);
        return int'(a >> SH);
    endfunction

    function automatic int code_of(int s);
        return (s == 0) ? 0 : ((s == 1) ? 1 : 3);
    endfunction

    function automatic logic [AW-1:0] addr_for(int b);
        logic [AW-1:0] a;
        a = AW'(b) << SH;
        a[SH-1:0] = SH'($urandom);
        return a;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) mdl[i] = 1;
            armed     = 1'b0;
            exp_fault = 1'b0;
        end else begin
            exp_fault = op_req && (mdl[blk_of(op_addr)] != 0);
            if (cmd_valid) begin
                if (armed) begin
                    mb = blk_of(cmd_addr);
                    case (cmd_code)
                        8'h01: if (mdl[mb] != 2) mdl[mb] = 1;
                        8'h2F: mdl[mb] = 2;
                        8'hD0: if (mdl[mb] == 1) mdl[mb] = 0;
                        default: ;
                    endcase
                end
                armed = (cmd_code == 8'h60);
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk(qry_status == 8'(code_of(mdl[blk_of(qry_addr)])), "R8 query status",
                int'(qry_status), code_of(mdl[blk_of(qry_addr)]));
            chk(op_permit == (mdl[blk_of(op_addr)] == 0), "R9 permit",
                int'(op_permit), int'(mdl[blk_of(op_addr)] == 0));
            chk(lock_fault == exp_fault, "R10 fault pulse", int'(lock_fault), int'(exp_fault));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] code, input int b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_addr  = addr_for(b);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic query_is(input int b, input int exp, input string tag);
        @(negedge clk);
        qry_addr = addr_for(b);
        #2;
        chk(qry_status == 8'(exp), tag, int'(qry_status), exp);
    endtask

    task automatic op_try(input int b, input bit fault, input string tag);
        @(negedge clk);
        op_req  = 1'b1;
        op_addr = addr_for(b);
        #2;
        chk(op_permit == !fault, tag, int'(op_permit), int'(!fault));
        @(negedge clk);
        op_req = 1'b0;
        #2;
        chk(lock_fault == fault, tag, int'(lock_fault), int'(fault));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
        $finish;
    end

    task automatic random_run(input int steps);
        logic [7:0] codes [6];
        codes = '{8'h60, 8'h01, 8'h2F, 8'hD0, 8'h70, 8'hFF};
        for (int s = 0; s < steps; s++) begin
            @(negedge clk);
            cmd_valid = ($urandom_range(0, 2) != 0);
            cmd_code  = codes[($urandom_range(0, 9) < 4) ? 0 : $urandom_range(1, 5)];
            if (cmd_code == 8'h2F && $urandom_range(0, 3) != 0) cmd_code = 8'hD0;
            cmd_addr  = addr_for($urandom_range(0, NB-1));
            qry_addr  = addr_for($urandom_range(0, NB-1));
            op_req    = $urandom_range(0, 1) == 1;
            op_addr   = addr_for($urandom_range(0, NB-1));
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        op_req    = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state of every block
        for (int b = 0; b < NB; b++) query_is(b, 1, "R1 reset status");
        op_try(7, 1'b1, "R1 reset permit");

        // R3: release block 3, others unchanged
        send(8'h60, 3);
        send(8'hD0, 3);
        query_is(3, 0, "R3 release");
        query_is(4, 1, "R11 neighbour untouched");
        op_try(3, 1'b0, "R9 open block permitted");
        op_try(5, 1'b1, "R10 fault on shut block");

        // R6: no set-up, or set-up cancelled by another opcode
        send(8'hD0, 5);
        query_is(5, 1, "R6 release without set-up");
        send(8'h60, 5);
        send(8'h70, 5);
        send(8'hD0, 5);
        query_is(5, 1, "R6 set-up cancelled");

        // R7: repeated set-up and idle gap
        send(8'h60, 5);
        send(8'h60, 5);
        repeat (3) @(negedge clk);
        send(8'hD0, 5);
        query_is(5, 0, "R7 repeated set-up with gap");

        // R2: lock again
        send(8'h60, 5);
        send(8'h01, 5);
        query_is(5, 1, "R2 lock");

        // R4 / R5: freeze and stay frozen
        send(8'h60, 3);
        send(8'h2F, 3);
        query_is(3, 3, "R4 freeze");
        send(8'h60, 3);
        send(8'hD0, 3);
        query_is(3, 3, "R5 release ignored when frozen");
        send(8'h60, 3);
        send(8'h01, 3);
        query_is(3, 3, "R5 lock keeps frozen");
        op_try(3, 1'b1, "R10 fault on frozen block");

        // R8: top block, low address bits ignored
        send(8'h60, NB-1);
        send(8'hD0, NB-1);
        query_is(NB-1, 0, "R8 low bits ignored");

        random_run(600);

        // R1: reset clears frozen state
        do_reset();
        query_is(3, 1, "R1 reset clears frozen");
        random_run(300);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule